// File: doc/BRIEF.md
# Multi-Hart Halt and Resume Tracker

This block keeps the run-control state of every hart behind a debug module. The debugger side writes a control word that carries an enable bit, a halt request, a resume request, a system-reset request and a hart index. The hart side posts notifications: one when a hart enters debug mode, one when it picks up a queued command, one when it leaves debug mode, and one when an exception occurs. The command controller sets the selected hart's go flag when it launches a command.

Every hart has its own set of flags: halted, resume acknowledged, go and resume. The block drives each hart's halt-request line and resume flag, and emits a one-cycle reset pulse to a single hart. It sends a release pulse to the command controller when the selected hart parks with no command pending. It also forms a 32-bit status word that describes the selected hart. Every output is registered, or is decoded from registers, so each output reflects an input one clock edge after that input is sampled.

Top module: `hart_dbg_tracker`

## Requirements
- R1: After reset, every per-hart flag and line is 0, the hart index is 0, the enable and exception flags are 0, and the status word reports hart 0 as running.
- R2: A control write with the enable bit set latches the hart index. If the index names an existing hart, the write also sets that hart's halt-request line to the halt bit and leaves every other line unchanged. `cur_halt` shows the live line of the selected hart.
- R3: A control write with the enable bit clear drops every halt-request line and clears the hart index, the enable flag and the exception flag. The per-hart halted flags keep their values.
- R4: A control write with enable and resume set, aimed at an existing hart, sets that hart's resume flag and clears its resume-acknowledge flag.
- R5: A halted notification carrying hart id k marks hart k as halted, whether or not k is selected.
- R6: `busy_release` pulses for exactly one cycle after a halted notification, and only when the id equals the selected hart and that hart's go flag is clear.
- R7: `go_set` sets the go flag of the selected hart. A going notification clears the go flag of the selected hart.
- R8: A resuming notification carrying hart id k clears halted for hart k, sets its resume-acknowledge flag and clears its resume flag.
- R9: Status bits in the word: [8] any halted, [9] all halted, [10] any running, [11] all running, [14] any nonexistent, [15] all nonexistent, [16] any resume-ack, [17] all resume-ack. Bits 8 and 9 are set if the selected hart exists and is halted. Bits 10 and 11 are set if it exists and is not halted. Bits 14 and 15 are set if the index is N or higher, and in that case bits 16 and 17 are 0.
- R10: The status word always holds 2 in bits [3:0] and 1 in bit 7. Every other bit not listed in R9 is 0.
- R11: A control write with enable and system reset set, aimed at an existing hart, raises that hart's `hart_rst` bit for exactly one cycle.
- R12: An exception notification sets `exc_err`, which stays set until a control write with the enable bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Control write strobe |
| ctl_active | input | 1 | Enable bit of the control write |
| ctl_halt | input | 1 | Halt request bit |
| ctl_resume | input | 1 | Resume request bit |
| ctl_sysrst | input | 1 | System-reset request bit |
| ctl_sel | input | SEL_W | Hart index of the control write |
| go_set | input | 1 | Command launch; sets the go flag of the selected hart |
| nt_halted | input | 1 | Hart entered debug mode |
| nt_going | input | 1 | Hart picked up the queued command |
| nt_resuming | input | 1 | Hart is leaving debug mode |
| nt_exception | input | 1 | Exception in debug mode |
| nt_id | input | SEL_W | Hart id carried by halted and resuming notifications |
| halt_req | output | N | Per-hart halt-request lines |
| resume_req | output | N | Per-hart resume flags |
| go_flag | output | N | Per-hart go flags |
| hart_rst | output | N | Per-hart one-cycle reset pulses |
| busy_release | output | 1 | Pulse that clears the command controller's busy state |
| exc_err | output | 1 | Sticky exception indication |
| active | output | 1 | Latched enable bit |
| cur_sel | output | SEL_W | Latched hart index |
| cur_halt | output | 1 | Live halt-request line of the selected hart |
| status | output | 32 | Status word of the selected hart |

## Verification
A corrupted halted or resume-acknowledge flag changes the status word on the next sample after the hart is selected. Because of this, the stimulus revisits harts after switching away from them. A stale go flag shows up as a missing or extra `busy_release` pulse one cycle after the halted notification. An index decode error shows up at once as a halt line, resume flag or reset pulse on the wrong hart, or as a missing nonexistent report for an out-of-range index.

// File: rtl/hart_dbg_tracker.sv
module hart_dbg_tracker #(
  parameter int N     = 4,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_active,
  input  logic             ctl_halt,
  input  logic             ctl_resume,
  input  logic             ctl_sysrst,
  input  logic [SEL_W-1:0] ctl_sel,
  input  logic             go_set,
  input  logic             nt_halted,
  input  logic             nt_going,
  input  logic             nt_resuming,
  input  logic             nt_exception,
  input  logic [SEL_W-1:0] nt_id,
  output logic [N-1:0]     halt_req,
  output logic [N-1:0]     resume_req,
  output logic [N-1:0]     go_flag,
  output logic [N-1:0]     hart_rst,
  output logic             busy_release,
  output logic             exc_err,
  output logic             active,
  output logic [SEL_W-1:0] cur_sel,
  output logic             cur_halt,
  output logic [31:0]      status
);
  localparam logic [3:0] VERSION = 4'd2;

  logic [N-1:0] sel_oh, id_oh, wr_oh, halted, resack;
  logic         wr_on, wr_off, sel_ok, sel_halted, sel_ack;

  assign wr_on  = ctl_wr & ctl_active;
  assign wr_off = ctl_wr & ~ctl_active;

  for (genvar i = 0; i < N; i++) begin : g_hart
    assign sel_oh[i] = (cur_sel == SEL_W'(i));
    assign id_oh[i]  = (nt_id   == SEL_W'(i));
    assign wr_oh[i]  = (ctl_sel == SEL_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        halted[i]     <= 1'b0;
        resack[i]     <= 1'b0;
        resume_req[i] <= 1'b0;
        go_flag[i]    <= 1'b0;
        halt_req[i]   <= 1'b0;
        hart_rst[i]   <= 1'b0;
      end else begin
        if (nt_halted && id_oh[i])        halted[i] <= 1'b1;
        else if (nt_resuming && id_oh[i]) halted[i] <= 1'b0;

        if (wr_on && ctl_resume && wr_oh[i]) begin
          resume_req[i] <= 1'b1;
          resack[i]     <= 1'b0;
        end else if (nt_resuming && id_oh[i]) begin
          resume_req[i] <= 1'b0;
          resack[i]     <= 1'b1;
        end

        if (go_set && sel_oh[i])        go_flag[i] <= 1'b1;
        else if (nt_going && sel_oh[i]) go_flag[i] <= 1'b0;

        if (wr_off)                  halt_req[i] <= 1'b0;
        else if (wr_on && wr_oh[i])  halt_req[i] <= ctl_halt;

        hart_rst[i] <= wr_on && ctl_sysrst && wr_oh[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_sel      <= '0;
      active       <= 1'b0;
      exc_err      <= 1'b0;
      busy_release <= 1'b0;
    end else begin
      if (ctl_wr) begin
        active  <= ctl_active;
        cur_sel <= ctl_active ? ctl_sel : '0;
      end
      if (wr_off)            exc_err <= 1'b0;
      else if (nt_exception) exc_err <= 1'b1;
      busy_release <= nt_halted && |(id_oh & sel_oh & ~go_flag);
    end
  end

  assign sel_ok     = |sel_oh;
  assign sel_halted = |(sel_oh & halted);
  assign sel_ack    = |(sel_oh & resack);
  assign cur_halt   = |(sel_oh & halt_req);

  always_comb begin
    status      = '0;
    status[3:0] = VERSION;
    status[7]   = 1'b1;
    status[8]   = sel_ok & sel_halted;
    status[9]   = sel_ok & sel_halted;
    status[10]  = sel_ok & ~sel_halted;
    status[11]  = sel_ok & ~sel_halted;
    status[14]  = ~sel_ok;
    status[15]  = ~sel_ok;
    status[16]  = sel_ok & sel_ack;
    status[17]  = sel_ok & sel_ack;
  end
endmodule

// File: rtl/hart_dbg_tracker_chk.sv
module hart_dbg_tracker_chk #(
  parameter int N     = 4,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic             ctl_active,
  input logic             ctl_resume,
  input logic [SEL_W-1:0] ctl_sel,
  input logic             nt_halted,
  input logic [N-1:0]     halt_req,
  input logic [N-1:0]     resume_req,
  input logic [N-1:0]     hart_rst,
  input logic             busy_release,
  input logic             exc_err,
  input logic [31:0]      status
);
  logic [N-1:0] mask_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mask_d <= '0;
    else        mask_d <= N'(1) << ctl_sel;

  p_release_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_release |-> $past(nt_halted));

  p_release_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_release && !$past(nt_halted, 1) |-> 1'b0);

  p_rst_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hart_rst));

  p_deact_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !ctl_active |=> halt_req == '0 && !exc_err);

  p_resume_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_active && ctl_resume && (32'(ctl_sel) < N) |=> |(resume_req & mask_d));

  p_status_const_r10: assert property (@(posedge clk) disable iff (!rst_n)
    status[3:0] == 4'd2 && status[7] && status[13:12] == 2'b00);

  p_status_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({status[9], status[11], status[15]}) == 1);
endmodule

bind hart_dbg_tracker hart_dbg_tracker_chk #(.N(N), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/tb_hart_dbg_tracker.sv
module tb_hart_dbg_tracker;
  localparam int N = 4;
  localparam int SEL_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 0, ctl_active = 0, ctl_halt = 0, ctl_resume = 0, ctl_sysrst = 0;
  logic [SEL_W-1:0] ctl_sel = '0, nt_id = '0;
  logic go_set = 0, nt_halted = 0, nt_going = 0, nt_resuming = 0, nt_exception = 0;
  logic [N-1:0] halt_req, resume_req, go_flag, hart_rst;
  logic busy_release, exc_err, active, cur_halt;
  logic [SEL_W-1:0] cur_sel;
  logic [31:0] status;

  int checks = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;

  hart_dbg_tracker #(.N(N), .SEL_W(SEL_W)) dut (.*);

  localparam logic [17:0] ST_RUN = 18'h00C82, ST_HALT = 18'h00382,
                          ST_RUNACK = 18'h30C82, ST_NONE = 18'h0C082;
  localparam logic [2:0] K_CTL = 0, K_HLT = 1, K_RSM = 2, K_GO = 3, K_GNG = 4;

  // {kind, id, halt, resume, status, halt_req, resume_req, go_flag}
  localparam logic [37:0] VEC [13] = '{
    {K_CTL, 3'd1, 1'b1, 1'b0, ST_RUN,    4'b0010, 4'b0000, 4'b0000},
    {K_HLT, 3'd1, 1'b0, 1'b0, ST_HALT,   4'b0010, 4'b0000, 4'b0000},
    {K_CTL, 3'd1, 1'b0, 1'b0, ST_HALT,   4'b0000, 4'b0000, 4'b0000},
    {K_GO,  3'd0, 1'b0, 1'b0, ST_HALT,   4'b0000, 4'b0000, 4'b0010},
    {K_GNG, 3'd0, 1'b0, 1'b0, ST_HALT,   4'b0000, 4'b0000, 4'b0000},
    {K_CTL, 3'd1, 1'b0, 1'b1, ST_HALT,   4'b0000, 4'b0010, 4'b0000},
    {K_RSM, 3'd1, 1'b0, 1'b0, ST_RUNACK, 4'b0000, 4'b0000, 4'b0000},
    {K_CTL, 3'd2, 1'b1, 1'b0, ST_RUN,    4'b0100, 4'b0000, 4'b0000},
    {K_HLT, 3'd3, 1'b0, 1'b0, ST_RUN,    4'b0100, 4'b0000, 4'b0000},
    {K_CTL, 3'd3, 1'b0, 1'b0, ST_HALT,   4'b0100, 4'b0000, 4'b0000},
    {K_CTL, 3'd5, 1'b0, 1'b0, ST_NONE,   4'b0100, 4'b0000, 4'b0000},
    {K_CTL, 3'd1, 1'b0, 1'b0, ST_RUNACK, 4'b0100, 4'b0000, 4'b0000},
    {K_CTL, 3'd1, 1'b0, 1'b1, ST_RUN,    4'b0100, 4'b0010, 4'b0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    ctl_wr = 0; ctl_active = 0; ctl_halt = 0; ctl_resume = 0; ctl_sysrst = 0;
    go_set = 0; nt_halted = 0; nt_going = 0; nt_resuming = 0; nt_exception = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic ctl(input logic act, input logic [SEL_W-1:0] s, input logic h,
                     input logic r, input logic sr);
    ctl_wr = 1; ctl_active = act; ctl_sel = s; ctl_halt = h; ctl_resume = r; ctl_sysrst = sr;
    step();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected below 100000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", status, 32'(ST_RUN));
    check("R1 lines", {halt_req, resume_req, go_flag, hart_rst}, 0);
    check("R1 flags", {busy_release, exc_err, active, cur_halt, cur_sel}, 0);

    foreach (VEC[k]) begin
      logic [37:0] v = VEC[k];
      case (v[37:35])
        K_CTL: begin ctl_wr = 1; ctl_active = 1; ctl_sel = v[34:32]; ctl_halt = v[31]; ctl_resume = v[30]; end
        K_HLT: begin nt_halted = 1; nt_id = v[34:32]; end
        K_RSM: begin nt_resuming = 1; nt_id = v[34:32]; end
        K_GO:  go_set = 1;
        default: nt_going = 1;
      endcase
      step();
      check("R2 R4 R5 R7 R8 R9 table status", status, 32'(v[29:12]));
      check("R2 R4 R8 table halt/resume", {halt_req, resume_req}, 32'(v[11:4]));
      check("R7 table go", 32'(go_flag), 32'(v[3:0]));
    end

    // R11 reset pulse to selected hart only, one cycle
    ctl(1, 3'd2, 0, 0, 1);
    check("R11 pulse", 32'(hart_rst), 32'b0100);
    step();
    check("R11 pulse ends", 32'(hart_rst), 0);
    ctl(1, 3'd6, 0, 0, 1);
    check("R11 no pulse for absent hart", 32'(hart_rst), 0);

    // R2 live halt level of selected hart
    ctl(1, 3'd2, 1, 0, 0);
    check("R2 cur_halt", {active, cur_halt, 1'b0, cur_sel}, {1'b1, 1'b1, 1'b0, 3'd2});

    // R6 busy release rules
    ctl(1, 3'd0, 0, 0, 0);
    go_set = 1; step();
    nt_halted = 1; nt_id = 3'd0; step();
    check("R6 no release with go set", 32'(busy_release), 0);
    check("R5 hart0 halted", status, 32'(ST_HALT));
    nt_going = 1; step();
    nt_halted = 1; nt_id = 3'd0; step();
    check("R6 release", 32'(busy_release), 1);
    step();
    check("R6 release one cycle", 32'(busy_release), 0);
    nt_halted = 1; nt_id = 3'd3; step();
    check("R6 no release for other hart", 32'(busy_release), 0);

    // R12 exception sticky, R3 deactivation
    nt_exception = 1; step();
    check("R12 exc set", 32'(exc_err), 1);
    step();
    check("R12 exc held", 32'(exc_err), 1);
    ctl(0, 3'd3, 1, 0, 0);
    check("R3 lines", {halt_req, active, exc_err, cur_sel}, 0);
    check("R3 halted kept", status, 32'(ST_HALT));
    ctl(1, 3'd3, 0, 0, 0);
    check("R3 hart3 halted kept", status, 32'(ST_HALT));

    finish_run();
  end
endmodule